// File: doc/BRIEF.md
# Prescaled Periodic Timer with Sticky Update Flag

This block is a general-purpose up-counting timer for periodic events. A programmable prescaler divides the input clock into counter ticks. The counter steps once per tick until it reaches the reload limit. On the tick after that it returns to zero and raises an update event. The update event sets a sticky flag, and the flag can drive an interrupt line. Software then clears the flag by writing a zero to it.

All settings sit behind a small synchronous register port that has one write strobe and a registered read path. The reload limit can take effect as soon as it is written. It can also be staged in a buffer that is copied to the active limit only on an update event, so that a new period never cuts short the current one. Control bits can suppress update events, or restrict the flag to real overflows. A write-only event register lets software force an update at any time.

Register addresses: 0 control, 1 status, 2 interrupt enable, 3 prescale, 4 reload, 5 count, 6 event (write-only, reads as 0).

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable register (control, status, interrupt enable, prescale, reload, count) reads 0 and `irq` is 0.
- R2: Start from a zeroed counter and prescaler, with prescale value P and reload value A. The first update event occurs on the (A+1)*(P+1)-th clock edge after the edge that writes control bit 0 (run) to 1. Updates then repeat with that period, and the counter returns to 0 on the tick after it reaches A.
- R3: With P=0 and A=0, an update event occurs on every clock edge while running.
- R4: Status bit 0 (the update flag) is set by an update event. Writing 0 to it clears it. Writing 1 to it has no effect.
- R5: `irq` is a register that is 1 one edge after the update flag and interrupt-enable bit 0 are both 1, and is 0 one edge after either is 0.
- R6: When control bit 0 is 0, the counter and the prescaler hold their values. The count register (address 5) can be written and read back.
- R7: With control bit 3 (reload buffering) at 0, a write to the reload register changes the active limit at once.
- R8: With control bit 3 at 1, a reload write does not change the active limit until the next update event. At that event the new value is copied in.
- R9: With control bit 1 (update off) at 1, no update event occurs: the flag is not set and the buffer is not copied. The counter still wraps to 0 after reaching the limit.
- R10: With control bit 2 (overflow-only) at 1, a forced update does not set the flag.
- R11: Writing 1 to bit 0 of the event register (address 6) forces an update. The counter and the prescaler go to 0, the buffered limit is loaded, and the flag is set unless control bit 2 is 1.
- R12: `rd_data` presents the register selected by `addr` one clock edge after `addr` is applied. Registers narrower than the data width are padded with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Each register write takes effect on the edge that samples `wr_en`. A read returns data one edge after the address is applied. `irq` lags the flag by one further edge, so the first update after a start is seen on `irq` at edge (A+1)*(P+1)+1. The bench counts edges from the start write until `irq` rises and compares that count with the value worked out from the formula. Periods after a buffered reload are measured from the flag-clearing write, waiting for `irq` to fall and then rise again. Count-hold results are read only after the stop write, whose edge still holds one tick.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_IEN  = 3'd2,
    A_PSC  = 3'd3,
    A_ARR  = 3'd4,
    A_CNT  = 3'd5,
    A_EVT  = 3'd6
  } reg_addr_e;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic buffered;
    logic ovf_only;
    logic no_upd;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] pcnt;
  logic         at_end;

  // compare with >= so a smaller divisor written mid-count ends the cycle at once
  assign at_end = (pcnt >= div);
  assign tick   = run && at_end && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)
      pcnt <= '0;
    else if (run)
      pcnt <= at_end ? '0 : pcnt + 1'b1;
  end

  a_r6_psc_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pcnt));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         force_upd,
  input  logic         no_upd,
  input  logic         buffered,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wd,
  input  logic [W-1:0] arr_wr,
  output logic [W-1:0] cnt,
  output logic         ovf_upd,
  output logic         sw_upd
);
  logic [W-1:0] arr_sh;
  logic [W-1:0] arr_act;
  logic         wrap;

  assign arr_act = buffered ? arr_sh : arr_wr;
  assign wrap    = tick && (cnt >= arr_act);
  assign ovf_upd = wrap && !force_upd && !cnt_we && !no_upd;
  assign sw_upd  = force_upd && !no_upd;

  // priority: forced update, then software count write, then tick
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (force_upd)
      cnt <= '0;
    else if (cnt_we)
      cnt <= cnt_wd;
    else if (tick)
      cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // shadow follows the written value while unbuffered, so switching modes is seamless
  always_ff @(posedge clk) begin
    if (rst)
      arr_sh <= '0;
    else if (!buffered || ovf_upd || sw_upd)
      arr_sh <= arr_wr;
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt >= arr_act) && !force_upd && !cnt_we) |=> (cnt == '0));
  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !force_upd && !cnt_we) |=> $stable(cnt));
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (buffered && !ovf_upd && !sw_upd) |=> $stable(arr_sh));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cnt,
  input  logic         ovf_upd,
  input  logic         sw_upd,
  output ctrl_t        ctrl,
  output logic [W-1:0] psc,
  output logic [W-1:0] arr,
  output logic         cnt_we,
  output logic         force_upd,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  reg_addr_e a;
  logic      flag;
  logic      ien;
  logic      flag_set;
  logic      flag_clr;

  assign a         = reg_addr_e'(addr);
  assign cnt_we    = wr_en && (a == A_CNT);
  assign force_upd = wr_en && (a == A_EVT) && wr_data[0];
  assign flag_set  = ovf_upd || (sw_upd && !ctrl.ovf_only);
  assign flag_clr  = wr_en && (a == A_STAT) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      ien  <= 1'b0;
      psc  <= '0;
      arr  <= '0;
    end else if (wr_en) begin
      case (a)
        A_CTRL:  ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_IEN:   ien  <= wr_data[0];
        A_PSC:   psc  <= wr_data;
        A_ARR:   arr  <= wr_data;
        default: ;
      endcase
    end
  end

  // hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (flag_set)
      flag <= 1'b1;
    else if (flag_clr)
      flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      irq <= flag && ien;
      case (a)
        A_CTRL:  rd_data <= {{(W-CTRL_W){1'b0}}, ctrl};
        A_STAT:  rd_data <= {{(W-1){1'b0}}, flag};
        A_IEN:   rd_data <= {{(W-1){1'b0}}, ien};
        A_PSC:   rd_data <= psc;
        A_ARR:   rd_data <= arr;
        A_CNT:   rd_data <= cnt;
        default: rd_data <= '0;
      endcase
    end
  end

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (!ien) |=> !irq);
  a_r9_no_update: assert property (@(posedge clk) disable iff (rst)
    ctrl.no_upd |-> (!ovf_upd && !sw_upd));
  a_r10_forced_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ovf_only && !ovf_upd && !flag) |=> !flag);
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  ctrl_t        ctrl;
  logic [W-1:0] psc;
  logic [W-1:0] arr;
  logic [W-1:0] cnt;
  logic         cnt_we;
  logic         force_upd;
  logic         tick;
  logic         ovf_upd;
  logic         sw_upd;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .cnt(cnt), .ovf_upd(ovf_upd), .sw_upd(sw_upd), .ctrl(ctrl),
    .psc(psc), .arr(arr), .cnt_we(cnt_we), .force_upd(force_upd),
    .rd_data(rd_data), .irq(irq)
  );

  tmr_prescale #(.W(W)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl.run), .clr(force_upd),
    .div(psc), .tick(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .force_upd(force_upd),
    .no_upd(ctrl.no_upd), .buffered(ctrl.buffered), .cnt_we(cnt_we),
    .cnt_wd(wr_data), .arr_wr(arr), .cnt(cnt), .ovf_upd(ovf_upd),
    .sw_upd(sw_upd)
  );
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam logic [15:0] RUN = 16'h1, NOUPD = 16'h2, OVF = 16'h4, BUF = 16'h8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        irq;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  tick_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                 .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(posedge clk);
    #1 v = rd_data;
  endtask

  task automatic prep(logic [15:0] p, logic [15:0] r, logic [15:0] c);
    wr(3'd0, c);
    wr(3'd2, 16'h1);
    wr(3'd3, p);
    wr(3'd4, r);
    wr(3'd6, 16'h1);
    wr(3'd1, 16'h0);
  endtask

  task automatic edges_to_irq(output int n);
    bit hit = 1'b0;
    n = 0;
    while (!hit && n < 400) begin
      @(posedge clk); #1;
      n++;
      if (irq) hit = 1'b1;
    end
  endtask

  task automatic measure(string tag, logic [15:0] c, int exp);
    int n;
    wr(3'd0, c | RUN);
    edges_to_irq(n);
    chk(tag, n, exp);
    wr(3'd0, c);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq after reset", int'(irq), 0);
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      chk("R1 R12 register reset value", int'(v), 0);
    end
  endtask

  task automatic t_period();
    prep(16'd0, 16'd0, OVF);
    measure("R3 P=0 A=0 every edge", OVF, 2);
    prep(16'd3, 16'd4, OVF);
    measure("R2 P=3 A=4 period", OVF, 21);
    prep(16'd2, 16'd1, OVF);
    measure("R2 P=2 A=1 period", OVF, 7);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    repeat (5) @(posedge clk);
    rd(3'd1, v); chk("R4 flag stays set", int'(v), 1);
    wr(3'd1, 16'h1);
    rd(3'd1, v); chk("R4 writing 1 keeps flag", int'(v), 1);
    wr(3'd1, 16'h0);
    rd(3'd1, v); chk("R4 writing 0 clears flag", int'(v), 0);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    prep(16'd0, 16'd0, OVF);
    wr(3'd2, 16'h0);
    wr(3'd0, OVF | RUN);
    repeat (5) @(posedge clk);
    wr(3'd0, OVF);
    rd(3'd1, v); chk("R5 flag set while disabled", int'(v), 1);
    chk("R5 irq masked", int'(irq), 0);
    wr(3'd2, 16'h1);
    chk("R5 irq one edge late", int'(irq), 0);
    @(posedge clk); #1;
    chk("R5 irq raised", int'(irq), 1);
    wr(3'd1, 16'h0);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    prep(16'd0, 16'd1000, OVF);
    wr(3'd0, OVF | RUN);
    repeat (9) @(posedge clk);
    wr(3'd0, OVF);
    rd(3'd5, v); chk("R6 count after ten ticks", int'(v), 10);
    repeat (7) @(posedge clk);
    rd(3'd5, v); chk("R6 count held while stopped", int'(v), 10);
    wr(3'd5, 16'hBEEF);
    rd(3'd5, v); chk("R6 count write readback", int'(v), 16'hBEEF);
  endtask

  task automatic t_immediate();
    prep(16'd0, 16'd50, OVF);
    wr(3'd4, 16'd3);
    measure("R7 unbuffered reload immediate", OVF, 5);
  endtask

  task automatic t_preload();
    logic [15:0] v;
    int n;
    int m;
    bit seen_low;
    bit hit;
    prep(16'd0, 16'd9, OVF | BUF);
    wr(3'd4, 16'd2);
    rd(3'd4, v); chk("R12 reload readback", int'(v), 2);
    wr(3'd0, OVF | BUF | RUN);
    edges_to_irq(n);
    chk("R8 buffered reload waits", n, 11);
    wr(3'd1, 16'h0);
    m = 0; seen_low = 1'b0; hit = 1'b0;
    while (!hit && m < 400) begin
      @(posedge clk); #1;
      m++;
      if (!irq) seen_low = 1'b1;
      else if (seen_low) hit = 1'b1;
    end
    chk("R8 new limit after update", m, 2);
    wr(3'd0, OVF | BUF);
  endtask

  task automatic t_noupd();
    logic [15:0] v;
    prep(16'd0, 16'd2, OVF);
    wr(3'd0, OVF | NOUPD | RUN);
    repeat (20) @(posedge clk);
    wr(3'd0, OVF | NOUPD);
    rd(3'd1, v); chk("R9 no flag with updates off", int'(v), 0);
    chk("R9 no irq with updates off", int'(irq), 0);
    rd(3'd5, v); chk("R9 counter still wraps", int'(v <= 16'd2), 1);
  endtask

  task automatic t_force();
    logic [15:0] v;
    prep(16'd0, 16'd100, 16'h0);
    wr(3'd5, 16'd55);
    wr(3'd6, 16'h1);
    rd(3'd5, v); chk("R11 force zeroes count", int'(v), 0);
    rd(3'd1, v); chk("R11 force sets flag", int'(v), 1);
    wr(3'd1, 16'h0);
    wr(3'd0, OVF);
    wr(3'd5, 16'd55);
    wr(3'd6, 16'h1);
    rd(3'd5, v); chk("R10 force zeroes count", int'(v), 0);
    rd(3'd1, v); chk("R10 overflow-only blocks flag", int'(v), 0);
    prep(16'd0, 16'd9, OVF | BUF);
    wr(3'd4, 16'd1);
    wr(3'd6, 16'h1);
    measure("R11 force loads buffer", OVF | BUF, 3);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_period();
    t_sticky();
    t_irq();
    t_hold();
    t_immediate();
    t_preload();
    t_noupd();
    t_force();
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end
endmodule